// File: doc/BRIEF.md
# Configurable I/O Pin Controller

This block manages one bidirectional board pin. A routed internal peripheral supplies an output level and an output-enable. The block turns them into pad controls for data, output-enable and pull resistor, according to a drive mode held in a configuration register. The pad input is brought into the clock domain through a synchronizer. Software can read it as a live level bit. A sticky change flag records any transition of the synchronized level, so a pulse as short as one clock period is still caught. Software clears the flag by writing zero to its bit.

Software reaches the block through a byte-wide address/data port. The block answers only inside its own 16-byte window. That window starts at 0xE060 plus 0x10 times the pin index. Offset 0 holds the level and flag. Offset 1 is the write-only configuration: drive mode in bits [1:0] and pull code in bits [3:2].

Top module: `pin_ctrl`

## Requirements
- R1: After reset, the drive mode is auto (0), the pull code is 0 (no pull), and the change flag is 0. A read of offset 0 with the pad held low returns 0x00.
- R2: Bit 0 of offset 0 returns the pad level once two clock edges have passed. Writes to bit 0 have no effect.
- R3: Bit 1 of offset 0 becomes 1 on the third clock edge after the pad level changes. It stays 1 until it is cleared.
- R4: A write to offset 0 with bit 1 equal to 0 clears the flag. A write with bit 1 equal to 1 leaves the flag unchanged.
- R5: When a level change and a clearing write reach the flag on the same clock edge, the flag ends up set.
- R6: A pad pulse lasting one clock period sets the flag.
- R7: Mode 0 (auto) drives the pad output with the peripheral's level, and the pad output-enable with the peripheral's enable.
- R8: Mode 1 (open-drain) enables the pad only when the peripheral enables it and outputs 0. The driven level is then 0.
- R9: Mode 2 (push-only) enables the pad only when the peripheral enables it and outputs 1. The pad data output is 1.
- R10: Mode 3 never enables the pad.
- R11: Pull code 1 gives pull-down (enable=1, up=0). Code 3 gives pull-up (enable=1, up=1). Codes 0 and 2 give no pull (enable=0, up=0).
- R12: The following all read back as 0: offset 1, unused offsets, and bits 7..2 of offset 0. Writes to addresses outside the window have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, at least 100 MHz |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid during a read strobe, 0 otherwise |
| periph_out_i | input | 1 | Output level from the routed peripheral |
| periph_oe_i | input | 1 | Output-enable from the routed peripheral |
| pad_in_i | input | 1 | Asynchronous pad input level |
| pad_out_o | output | 1 | Pad output data |
| pad_oe_o | output | 1 | Pad output-enable |
| pad_pull_en_o | output | 1 | Pull resistor enable |
| pad_pull_up_o | output | 1 | Pull direction, 1 = up |

## Verification
Assertions check the following on every cycle:
- the open-drain, push-only and off drive limits;
- the pull decode;
- the set, hold and clear behaviour of the flag, including set winning over a simultaneous clear;
- zero reserved read bits.

Other behaviour can only be shown by the bench's scenarios:
- the exact cycle at which the level and flag appear after a pad change;
- the capture of a one-period glitch;
- the write-only config reading back 0;
- the ignoring of writes to a neighbouring pin's window.

// File: rtl/pin_ctrl_pkg.sv
package pin_ctrl_pkg;
  typedef enum logic [1:0] {
    DRV_AUTO       = 2'd0,
    DRV_OPEN_DRAIN = 2'd1,
    DRV_PUSH_ONLY  = 2'd2,
    DRV_OFF        = 2'd3
  } drv_mode_e;

  localparam int unsigned OFF_LEVEL = 0;
  localparam int unsigned OFF_CFG   = 1;
  localparam int unsigned WIN_BITS  = 4;

  // returns {pull_up, pull_en}
  function automatic logic [1:0] pull_decode(input logic [1:0] code);
    logic [1:0] r;
    case (code)
      2'd1:    r = 2'b01;
      2'd3:    r = 2'b11;
      default: r = 2'b00;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain <= '0;
        else         chain <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain <= '0;
        else         chain <= {chain[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pin_event.sv
module pin_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic clr_i,
  output logic change_o,
  output logic flag_o
);
  logic prev_q;
  logic flag_q;

  assign change_o = level_i ^ prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= level_i;
      // a new change outranks a clear in the same cycle
      flag_q <= change_o | (flag_q & ~clr_i);
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pin_drive.sv
module pin_drive
  import pin_ctrl_pkg::*;
(
  input  drv_mode_e  mode_i,
  input  logic [1:0] pull_i,
  input  logic       periph_out_i,
  input  logic       periph_oe_i,
  output logic       pad_out_o,
  output logic       pad_oe_o,
  output logic       pull_en_o,
  output logic       pull_up_o
);
  always_comb begin
    pad_out_o = 1'b0;
    pad_oe_o  = 1'b0;
    case (mode_i)
      DRV_AUTO: begin
        pad_out_o = periph_out_i;
        pad_oe_o  = periph_oe_i;
      end
      DRV_OPEN_DRAIN: begin
        pad_out_o = 1'b0;
        pad_oe_o  = periph_oe_i & ~periph_out_i;
      end
      DRV_PUSH_ONLY: begin
        pad_out_o = 1'b1;
        pad_oe_o  = periph_oe_i & periph_out_i;
      end
      default: begin
        pad_out_o = 1'b0;
        pad_oe_o  = 1'b0;
      end
    endcase
  end

  assign {pull_up_o, pull_en_o} = pull_decode(pull_i);
endmodule

// File: rtl/pin_regs.sv
module pin_regs
  import pin_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              level_i,
  input  logic              flag_i,
  output drv_mode_e         mode_o,
  output logic [1:0]        pull_o,
  output logic              clr_o
);
  localparam int unsigned HI_W = ADDR_W - WIN_BITS;

  logic                hit;
  logic [WIN_BITS-1:0] offs;
  logic                wr_level, wr_cfg, rd_level;
  drv_mode_e           mode_q;
  logic [1:0]          pull_q;
  logic                unused_wdata;

  assign hit  = sel_i && (addr_i[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS]);
  assign offs = addr_i[WIN_BITS-1:0];

  assign wr_level = hit && we_i && (offs == WIN_BITS'(OFF_LEVEL));
  assign wr_cfg   = hit && we_i && (offs == WIN_BITS'(OFF_CFG));
  assign rd_level = hit && !we_i && (offs == WIN_BITS'(OFF_LEVEL));

  assign clr_o = wr_level && !wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= DRV_AUTO;
      pull_q <= 2'd0;
    end else if (wr_cfg) begin
      mode_q <= drv_mode_e'(wdata_i[1:0]);
      pull_q <= wdata_i[3:2];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_level) rdata_o[1:0] = {flag_i, level_i};
  end

  assign mode_o       = mode_q;
  assign pull_o       = pull_q;
  assign unused_wdata = ^{wdata_i[DATA_W-1:4], HI_W[0]};
endmodule

// File: rtl/pin_ctrl.sv
module pin_ctrl
  import pin_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PIN_IDX   = 0,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              periph_out_i,
  input  logic              periph_oe_i,
  input  logic              pad_in_i,
  output logic              pad_out_o,
  output logic              pad_oe_o,
  output logic              pad_pull_en_o,
  output logic              pad_pull_up_o
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(32'hE060 + 32'h10 * PIN_IDX);

  logic       lvl_sync;
  logic       ev_change, ev_flag, ev_clr;
  drv_mode_e  cfg_mode;
  logic [1:0] cfg_pull;

  pin_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (lvl_sync)
  );

  pin_event u_event (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (lvl_sync),
    .clr_i   (ev_clr),
    .change_o(ev_change),
    .flag_o  (ev_flag)
  );

  pin_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (bus_sel_i),
    .we_i   (bus_we_i),
    .addr_i (bus_addr_i),
    .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o),
    .level_i(lvl_sync),
    .flag_i (ev_flag),
    .mode_o (cfg_mode),
    .pull_o (cfg_pull),
    .clr_o  (ev_clr)
  );

  pin_drive u_drive (
    .mode_i      (cfg_mode),
    .pull_i      (cfg_pull),
    .periph_out_i(periph_out_i),
    .periph_oe_i (periph_oe_i),
    .pad_out_o   (pad_out_o),
    .pad_oe_o    (pad_oe_o),
    .pull_en_o   (pad_pull_en_o),
    .pull_up_o   (pad_pull_up_o)
  );
endmodule

// File: rtl/pin_ctrl_chk.sv
module pin_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic [1:0]        pull_i,
  input logic              pad_out_i,
  input logic              pad_oe_i,
  input logic              pull_en_i,
  input logic              pull_up_i,
  input logic              change_i,
  input logic              flag_i,
  input logic              clr_i,
  input logic [DATA_W-1:0] rdata_i
);
  AST_OPEN_DRAIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && pad_oe_i) |-> !pad_out_i); // R8
  AST_PUSH_ONLY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && pad_oe_i) |-> pad_out_i); // R9
  AST_OFF_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |-> !pad_oe_i); // R10
  AST_PULL_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_i == 2'd0 || pull_i == 2'd2) |-> (!pull_en_i && !pull_up_i)); // R11
  AST_PULL_UP_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_up_i |-> (pull_en_i && pull_i == 2'd3)); // R11
  AST_EVENT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_i |=> flag_i); // R3
  AST_EVENT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !clr_i) |=> flag_i); // R3
  AST_EVENT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !change_i) |=> !flag_i); // R4
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && change_i) |=> flag_i); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_i[DATA_W-1:2] == '0); // R12
endmodule

bind pin_ctrl pin_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (cfg_mode),
  .pull_i   (cfg_pull),
  .pad_out_i(pad_out_o),
  .pad_oe_i (pad_oe_o),
  .pull_en_i(pad_pull_en_o),
  .pull_up_i(pad_pull_up_o),
  .change_i (ev_change),
  .flag_i   (ev_flag),
  .clr_i    (ev_clr),
  .rdata_i  (bus_rdata_o)
);

// File: tb/pin_ctrl_test.sv
module pin_ctrl_test;
  localparam logic [15:0] BASE  = 16'hE080; // pin index 2
  localparam logic [15:0] OTHER = 16'hE090;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        p_out = 1'b0, p_oe = 1'b0, pad_in = 1'b0;
  logic        pad_out, pad_oe, pull_en, pull_up;

  int total = 0, bad = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    int         kind;
    logic [7:0] exp;
  } item_t;
  item_t sb[$];
  logic  obs_req = 1'b0;
  int    obs_kind = 0;

  always #4 clk = ~clk;

  pin_ctrl #(.PIN_IDX(2)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .periph_out_i(p_out), .periph_oe_i(p_oe), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .pad_pull_en_o(pull_en), .pad_pull_up_o(pull_up)
  );

  // monitor: samples mid-cycle and pops expected items
  always @(negedge clk) begin
    #2;
    if (obs_req) begin
      logic [7:0] act;
      item_t it;
      act = (obs_kind == 1) ? {4'b0, pull_up, pull_en, pad_oe, pad_out} : rdata;
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL scoreboard empty act=%h", act);
      end else begin
        it = sb.pop_front();
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic expect_rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    sb.push_back('{tag, 0, e});
    obs_kind = 0; obs_req = 1'b1;
    @(negedge clk);
    sel = 1'b0; obs_req = 1'b0;
  endtask

  // e = {pull_up, pull_en, oe, out}
  task automatic expect_pad(input logic [3:0] e, input string tag);
    @(negedge clk);
    sb.push_back('{tag, 1, {4'b0, e}});
    obs_kind = 1; obs_req = 1'b1;
    @(negedge clk);
    obs_req = 1'b0;
  endtask

  task automatic periph(input logic o, input logic e);
    @(negedge clk);
    p_out = o; p_oe = e;
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    expect_rd(BASE, 8'h00, "R1 level reg after reset");
    expect_pad(4'b0000, "R1 pads after reset");
    // R7 auto mode
    periph(1, 1); expect_pad(4'b0011, "R7 auto out1 oe1");
    periph(0, 1); expect_pad(4'b0010, "R7 auto out0 oe1");
    periph(1, 0); expect_pad(4'b0001, "R7 auto out1 oe0");
    // R8 open-drain
    bus_wr(BASE + 16'd1, 8'h01);
    periph(0, 1); expect_pad(4'b0010, "R8 od drives low");
    periph(1, 1); expect_pad(4'b0000, "R8 od releases on 1");
    periph(0, 0); expect_pad(4'b0000, "R8 od oe0");
    // R9 push-only
    bus_wr(BASE + 16'd1, 8'h02);
    periph(1, 1); expect_pad(4'b0011, "R9 push drives high");
    periph(0, 1); expect_pad(4'b0001, "R9 push releases on 0");
    // R10 mode 3
    bus_wr(BASE + 16'd1, 8'h03);
    periph(1, 1); expect_pad(4'b0000, "R10 mode3 hi-z out1");
    periph(0, 1); expect_pad(4'b0000, "R10 mode3 hi-z out0");
    // R11 pull codes with mode 0
    periph(0, 0);
    bus_wr(BASE + 16'd1, 8'h04); expect_pad(4'b0100, "R11 pull-down");
    bus_wr(BASE + 16'd1, 8'h0C); expect_pad(4'b1100, "R11 pull-up");
    bus_wr(BASE + 16'd1, 8'h08); expect_pad(4'b0000, "R11 code2 no pull");
    bus_wr(BASE + 16'd1, 8'h0C);
    bus_wr(BASE + 16'd1, 8'hF0); expect_pad(4'b0000, "R11 code0 no pull");
    // R12 reads of config and unused offset
    expect_rd(BASE + 16'd1, 8'h00, "R12 config reads zero");
    expect_rd(BASE + 16'd2, 8'h00, "R12 unused offset reads zero");
    // R12 write to another pin's window ignored
    bus_wr(OTHER + 16'd1, 8'h01);
    periph(1, 1); expect_pad(4'b0011, "R12 foreign write ignored");
    // R2 level follows pad, R3 flag set
    @(negedge clk); pad_in = 1'b1;
    idle(3);
    expect_rd(BASE, 8'h03, "R2 R3 level high and flag");
    // R4 clear with bit0 write ignored (R2)
    bus_wr(BASE, 8'hFD);
    expect_rd(BASE, 8'h01, "R4 flag cleared, R2 bit0 write ignored");
    bus_wr(BASE, 8'h02);
    expect_rd(BASE, 8'h01, "R4 writing 1 does not set flag");
    // R3 falling change, sticky
    @(negedge clk); pad_in = 1'b0;
    idle(3);
    expect_rd(BASE, 8'h02, "R3 flag on fall");
    idle(5);
    expect_rd(BASE, 8'h02, "R3 flag sticky");
    bus_wr(BASE, 8'h02);
    expect_rd(BASE, 8'h02, "R4 writing 1 keeps flag");
    bus_wr(BASE, 8'h00);
    expect_rd(BASE, 8'h00, "R4 flag cleared");
    // R6 one-period pulse
    @(negedge clk); pad_in = 1'b1;
    @(negedge clk); pad_in = 1'b0;
    idle(4);
    expect_rd(BASE, 8'h02, "R6 short pulse caught");
    bus_wr(BASE, 8'h00);
    expect_rd(BASE, 8'h00, "R6 cleared after pulse");
    // R5 change and clear on the same edge
    @(negedge clk); pad_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = BASE; wdata = 8'h00;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
    expect_rd(BASE, 8'h03, "R5 set wins over clear");
    idle(3);
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL scoreboard leftover act=%0d exp=0", sb.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule